// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider Pair

This block derives a slower clock from a fast input clock with two divider stages in series. Stage A counts cycles of the input clock. Stage B counts the rising edges of stage A's output, so the overall ratio is the product of the two stage ratios. Each stage has four settings: how long its output stays high, how long it stays low, the level it starts from, and a phase delay. The phase delay is the number of input cycles the stage waits after a synchronization release before it starts counting. Either stage can be bypassed, and its input then passes straight to its output.

A chip-level synchronous `sync_req` input holds both stages at their start levels while it is high. When it is released, every divider in the chip restarts in step. A shared control word can make the block ignore `sync_req`, and it can force the output high. New high and low counts are written into a pending copy. A stage adopts that copy only while held by SYNC, or at the moment it returns to its start level. A period that is under way therefore never ends early or late.

All state runs on `clk`. A stage advances only on cycles in which its input ticks. `rst` is synchronous and active high.

Top module: `cdiv_pair`

## Requirements
- R1: With high field H, a running stage keeps its output high for H+1 of its input cycles, so field 0 gives a one-cycle phase.
- R2: With low field L, a running stage keeps its output low for L+1 of its input cycles. A stage ratio is H+L+2, from 2 to 32.
- R3: Stage B advances only on rising edges of stage A's output. The output period is the product of the two stage ratios.
- R4: When a stage's bypass bit is set, its counting is frozen and its input passes to its output. With both bypassed, `div_out` follows `clk`.
- R5: While `sync_req` is high and obeyed, each stage holds its start level. After release, a stage with start bit 0 begins low and one with start bit 1 begins high.
- R6: After release, a stage with phase field P holds its start level for P input cycles before it starts counting its first segment.
- R7: With control bit 0 (nosync) set, `sync_req` has no effect and the dividers keep running.
- R8: With control bits 0 and 1 (nosync and force) both set, `div_out` is 1. The force bit alone, with nosync clear, has no effect.
- R9: A new high/low count written while a stage runs takes effect when the stage next returns to its start level, or at SYNC. The segment under way keeps its old length.
- R10: A write with `wr_addr` 0 sets stage A and 1 sets stage B. The stage word is high[3:0], low[7:4], phase[11:8], start[12], bypass[13]. `wr_addr` 2 sets control with nosync in bit 0 and force in bit 1.
- R11: Reset clears every field. After reset, `div_out` is 0 and the block divides by 4 with no phase delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_req | input | 1 | Chip-level synchronization, high holds the stages |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 stage A, 1 stage B, 2 control |
| wr_data | input | 14 | Register write data |
| div_out | output | 1 | Divided clock output |

## Verification
The bench builds the block with its defaults: 4-bit fields and two stages. Every field can reach its end values, so the longest case is a 32 by 32 cascade with a 15-cycle phase on both stages, about two thousand cycles. The vectors combine start levels, phases and unequal high/low counts in both stages. The release-to-first-edge delay and the two following widths are predicted from the field values alone. Bypass, forcing, ignored SYNC and a count rewrite in the middle of a period are then driven as directed cases.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int CNT_W  = 4;
  localparam int NSTAGE = 2;
  localparam int WORD_W = 3 * CNT_W + 2;
  localparam int ADDR_W = $clog2(NSTAGE + 1);

  // bypass[13] start[12] phase[11:8] low[7:4] high[3:0]
  typedef struct packed {
    logic             bypass;
    logic             start;
    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] low;
    logic [CNT_W-1:0] high;
  } stage_cfg_t;

  typedef struct packed {
    logic force_hi;
    logic nosync;
  } ctl_t;

  // length field of the segment at level lvl (segment lasts field+1 ticks)
  function automatic logic [CNT_W-1:0] seg_field(input logic [CNT_W-1:0] hi,
                                                 input logic [CNT_W-1:0] lo,
                                                 input logic lvl);
    return lvl ? hi : lo;
  endfunction

  function automatic int unsigned stage_ratio(input stage_cfg_t c);
    return int'(c.high) + int'(c.low) + 2;
  endfunction
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output stage_cfg_t        cfg_o [NSTAGE],
  output ctl_t              ctl_o
);
  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage_reg
    always_ff @(posedge clk) begin
      if (rst)
        cfg_o[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        cfg_o[i] <= stage_cfg_t'(wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctl_o <= '0;
    else if (wr_en && wr_addr == ADDR_W'(NSTAGE))
      ctl_o <= ctl_t'(wr_data[1:0]);
  end
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             in_tick,
  input  stage_cfg_t       cfg,
  output logic             lvl_o,
  output logic             rise_o,
  output logic             wrap_o,
  output logic             wait_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] lo_o
);
  logic             lvl_q, wait_q;
  logic [CNT_W-1:0] cnt_q, ph_q, hi_q, lo_q;

  logic run, toggle, next_lvl;
  assign run      = in_tick && !cfg.bypass && !hold;
  assign toggle   = run && !wait_q && (cnt_q == '0);
  assign next_lvl = !lvl_q;

  // back at the start level: one full period is complete
  assign wrap_o = toggle && (next_lvl == cfg.start);
  assign rise_o = cfg.bypass ? in_tick : (toggle && !lvl_q);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      lvl_q  <= cfg.start;
      wait_q <= (cfg.phase != '0);
      ph_q   <= cfg.phase;
      cnt_q  <= seg_field(cfg.high, cfg.low, cfg.start);
      hi_q   <= cfg.high;
      lo_q   <= cfg.low;
    end else if (run) begin
      if (wait_q) begin
        ph_q <= ph_q - 1'b1;
        if (ph_q == CNT_W'(1)) wait_q <= 1'b0;
      end else if (cnt_q == '0) begin
        lvl_q <= next_lvl;
        if (wrap_o) begin
          hi_q  <= cfg.high;
          lo_q  <= cfg.low;
          cnt_q <= seg_field(cfg.high, cfg.low, next_lvl);
        end else begin
          cnt_q <= seg_field(hi_q, lo_q, next_lvl);
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign wait_o = wait_q;
  assign cnt_o  = cnt_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/cdiv_pair.sv
module cdiv_pair
  import cdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              div_out
);
  stage_cfg_t       cfg [NSTAGE];
  ctl_t             ctl;
  logic             hold;
  logic             lvl0, lvl1, rise0, rise1, wrap0, wrap1, wait0, wait1;
  logic [CNT_W-1:0] cnt0, cnt1, hi0, hi1, lo0, lo1;
  logic             pass_a, pass_b;

  cdiv_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_o(cfg), .ctl_o(ctl)
  );

  assign hold = sync_req && !ctl.nosync;

  // stage A ticks every input cycle
  cdiv_stage u_st_a (
    .clk(clk), .rst(rst), .hold(hold), .in_tick(1'b1), .cfg(cfg[0]),
    .lvl_o(lvl0), .rise_o(rise0), .wrap_o(wrap0), .wait_o(wait0),
    .cnt_o(cnt0), .hi_o(hi0), .lo_o(lo0)
  );

  // stage B ticks on stage A rising edges
  cdiv_stage u_st_b (
    .clk(clk), .rst(rst), .hold(hold), .in_tick(rise0), .cfg(cfg[1]),
    .lvl_o(lvl1), .rise_o(rise1), .wrap_o(wrap1), .wait_o(wait1),
    .cnt_o(cnt1), .hi_o(hi1), .lo_o(lo1)
  );

  always_comb begin
    pass_a  = cfg[0].bypass ? clk : lvl0;
    pass_b  = cfg[1].bypass ? pass_a : lvl1;
    div_out = (ctl.nosync && ctl.force_hi) ? 1'b1 : pass_b;
  end
endmodule

// File: rtl/cdiv_pair_chk.sv
module cdiv_pair_chk
  import cdiv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              div_out,
  input logic              hold,
  input logic              start_b,
  input logic              byp_b,
  input logic              lvl0,
  input logic              lvl1,
  input logic              rise0,
  input logic              rise1,
  input logic              wrap0,
  input logic              wrap1,
  input logic              wait0,
  input logic              wait1,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1,
  input logic [CNT_W-1:0]  hi0,
  input logic [CNT_W-1:0]  hi1,
  input logic [CNT_W-1:0]  lo0,
  input logic [CNT_W-1:0]  lo1
);
  a_r1_cnt_bound_a: assert property (@(posedge clk) disable iff (rst)
    cnt0 <= (lvl0 ? hi0 : lo0));
  a_r2_cnt_bound_b: assert property (@(posedge clk) disable iff (rst)
    cnt1 <= (lvl1 ? hi1 : lo1));

  a_r3_b_steps_on_a_rise: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hold) && lvl1 != $past(lvl1)) |-> $past(rise0));
  a_r3_b_rise_goes_high: assert property (@(posedge clk) disable iff (rst)
    (rise1 && !byp_b && !hold) |=> lvl1);

  a_r5_hold_start: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> (lvl1 == $past(start_b)));

  a_r6_phase_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hold) && ($past(wait0) || $past(wait1)))
      |-> ($past(wait0) ? $stable(lvl0) : 1'b1) && ($past(wait1) ? $stable(lvl1) : 1'b1));

  a_r8_force_high: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == ADDR_W'(NSTAGE) && wr_data[1:0] == 2'b11) |-> div_out);

  a_r9_shadow_a: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (hi0 != $past(hi0) || lo0 != $past(lo0))) |-> $past(hold || wrap0));
  a_r9_shadow_b: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (hi1 != $past(hi1) || lo1 != $past(lo1))) |-> $past(hold || wrap1));
endmodule

bind cdiv_pair cdiv_pair_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .div_out(div_out), .hold(hold), .start_b(cfg[1].start), .byp_b(cfg[1].bypass),
  .lvl0(lvl0), .lvl1(lvl1), .rise0(rise0), .rise1(rise1),
  .wrap0(wrap0), .wrap1(wrap1), .wait0(wait0), .wait1(wait1),
  .cnt0(cnt0), .cnt1(cnt1), .hi0(hi0), .hi1(hi1), .lo0(lo0), .lo1(lo1)
);

// File: tb/cdiv_pair_test.sv
module cdiv_pair_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [13:0] wr_data = '0;
  logic        div_out;

  int n_chk = 0;
  int n_bad = 0;
  logic cur;

  cdiv_pair uut (
    .clk(clk), .rst(rst), .sync_req(sync_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .div_out(div_out)
  );

  always #10 clk = ~clk;

  // nibbles: hA lA pA sA hB lB pB sB
  localparam logic [31:0] VEC [5] = '{
    32'h0000_0000, 32'h2100_1000, 32'h3321_0210, 32'hFFF1_FFF1, 32'h1430_2051
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] word(input logic byp, input logic st,
                                       input int ph, input int lo, input int hi);
    return {byp, st, 4'(ph), 4'(lo), 4'(hi)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [13:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic smp();
    @(negedge clk); cur = div_out;
  endtask

  task automatic run_len(output int n);
    logic l = cur;
    n = 0;
    while (cur == l && n < 5000) begin n++; smp(); end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic toggles(input int k, output int t);
    logic prev;
    smp(); prev = cur; t = 0;
    for (int i = 0; i < k; i++) begin
      smp(); if (cur != prev) t++; prev = cur;
    end
  endtask

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog: got 0, expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    int d, w1, w2, t, ones;
    // R11 reset state and default divide by 4
    idle(3);
    chk("R11 reset level", int'(div_out), 0);
    rst = 1'b0;
    d = 0; smp();
    while (cur == 1'b0 && d < 5000) begin d++; smp(); end
    chk("R11 default delay", d, 0);
    run_len(w1); run_len(w2);
    chk("R11 default high", w1, 2);
    chk("R11 default low", w2, 2);

    // vector table: R1 R2 R3 R5 R6 R10
    foreach (VEC[k]) begin
      int ha, la, pa, sa, hb, lb, pb, sb, ta, r0, e2;
      ha = int'(VEC[k][31:28]); la = int'(VEC[k][27:24]);
      pa = int'(VEC[k][23:20]); sa = int'(VEC[k][19:16]);
      hb = int'(VEC[k][15:12]); lb = int'(VEC[k][11:8]);
      pb = int'(VEC[k][7:4]);   sb = int'(VEC[k][3:0]);
      ta = ha + la + 2;
      r0 = pa + ((sa != 0) ? ta : la + 1);
      e2 = r0 + (pb + ((sb != 0) ? hb : lb)) * ta;
      sync_req = 1'b1;
      wr(2'd0, word(1'b0, sa[0], pa, la, ha));
      wr(2'd1, word(1'b0, sb[0], pb, lb, hb));
      wr(2'd2, 14'd0);
      idle(3);
      chk("R5 level held in sync", int'(div_out), sb);
      sync_req = 1'b0;
      d = 0; smp();
      while (cur == sb[0] && d < 5000) begin d++; smp(); end
      chk("R6 R3 release delay", d, e2 - 1);
      run_len(w1); run_len(w2);
      chk((sb != 0) ? "R2 first low width" : "R1 first high width", w1,
          ((sb != 0) ? lb + 1 : hb + 1) * ta);
      chk((sb != 0) ? "R1 next high width" : "R2 next low width", w2,
          ((sb != 0) ? hb + 1 : lb + 1) * ta);
    end

    // R4 bypass stage B only: output is stage A
    sync_req = 1'b1;
    wr(2'd0, word(1'b0, 1'b0, 0, 1, 2));
    wr(2'd1, word(1'b1, 1'b0, 0, 0, 0));
    idle(2); sync_req = 1'b0;
    d = 0; smp();
    while (cur == 1'b0 && d < 5000) begin d++; smp(); end
    run_len(w1); run_len(w2);
    chk("R4 B bypass delay", d, 1);
    chk("R4 B bypass high", w1, 3);
    chk("R4 B bypass low", w2, 2);

    // R4 bypass stage A: stage B counts input cycles
    sync_req = 1'b1;
    wr(2'd0, word(1'b1, 1'b0, 0, 0, 0));
    wr(2'd1, word(1'b0, 1'b0, 1, 2, 1));
    idle(2); sync_req = 1'b0;
    d = 0; smp();
    while (cur == 1'b0 && d < 5000) begin d++; smp(); end
    run_len(w1); run_len(w2);
    chk("R4 A bypass delay", d, 3);
    chk("R4 A bypass high", w1, 2);
    chk("R4 A bypass low", w2, 3);

    // R4 both bypassed: output follows the input clock
    wr(2'd1, word(1'b1, 1'b0, 0, 0, 0));
    t = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #5; if (div_out !== 1'b1) t++;
      @(negedge clk); #5; if (div_out !== 1'b0) t++;
    end
    chk("R4 clock pass-through errors", t, 0);

    // R7 nosync: SYNC ignored
    sync_req = 1'b1;
    wr(2'd0, word(1'b0, 1'b0, 0, 0, 0));
    wr(2'd1, word(1'b0, 1'b0, 0, 0, 0));
    wr(2'd2, 14'b01);
    toggles(20, t);
    chk("R7 running while sync high", int'(t >= 9), 1);

    // R8 force with nosync: constant high whatever SYNC does
    wr(2'd2, 14'b11);
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      sync_req = ~sync_req; smp(); if (cur) ones++;
    end
    chk("R8 forced high samples", ones, 20);

    // R8 force without nosync: no effect, SYNC still holds then releases
    sync_req = 1'b1;
    wr(2'd2, 14'b10);
    ones = 0;
    for (int i = 0; i < 20; i++) begin smp(); if (cur) ones++; end
    chk("R8 force ignored, held at start", ones, 0);
    sync_req = 1'b0;
    toggles(20, t);
    chk("R8 force ignored, running", int'(t >= 9), 1);

    // R9 count rewrite mid period, SYNC unused
    sync_req = 1'b1;
    wr(2'd1, word(1'b0, 1'b0, 0, 3, 3));
    wr(2'd2, 14'b00);
    idle(2); sync_req = 1'b0;
    wr(2'd2, 14'b01);
    smp(); d = 0;
    while (cur == 1'b1 && d < 100) begin d++; smp(); end
    while (cur == 1'b0 && d < 200) begin d++; smp(); end
    w1 = 1;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = word(1'b0, 1'b0, 0, 1, 1);
    smp(); wr_en = 1'b0;
    while (cur == 1'b1 && w1 < 5000) begin w1++; smp(); end
    chk("R9 running high keeps old length", w1, 8);
    run_len(w1); run_len(w2);
    chk("R9 new low after wrap", w1, 4);
    chk("R9 new high after wrap", w2, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule